// File: doc/BRIEF.md
# Pulse-Disciplined Timestamp Counter Aligner

This block runs a local timestamp counter, split into whole seconds and sub-second ticks, and steers its rate so that its second boundary follows a once-per-second marker pulse from a reference clock. The counter advances each clock by a fractional rate word. The marker arrives asynchronously. Each accepted marker is taken as a true second boundary. The block measures how far the counter's own boundary lies from the marker, reports that signed error, and snaps the sub-second count to zero. It then nudges the rate word by the error times a programmable integral gain.

The first marker after enabling, or after a timeout, only aligns the phase. Later markers also correct the rate. The lock indicator rises after a run of markers whose error magnitude stays within a programmable threshold. A missing marker drops lock and sets a sticky timeout flag. A small write-only configuration port sets the enable, the gain and the threshold. Disabling the block stops all steering and returns the counter to its nominal rate.

Top module: `pps_rate_aligner`

## Requirements
- R1: While reset is asserted, time_sec and time_sub are 0, rate_word is nominal (1 << FRAC_W, one tick per clock), locked and pps_timeout are 0. After reset the gain is 0x70, the threshold is 0x26C and the block is enabled.
- R2: The marker input passes through a two-flop synchronizer, and only its rising edge counts. A marker held high for many clocks is one event.
- R3: On every clock, the fractional accumulator plus rate_word produces an integer step that is added to time_sub. When time_sub would reach SEC_TICKS it wraps by subtracting SEC_TICKS, and time_sec increments. time_sub is always below SEC_TICKS.
- R4: The first marker after enable or after a timeout sets time_sub and the fraction to 0 at the processing edge. It leaves rate_word unchanged and does not count toward lock.
- R5: For each accepted marker, p is the sub-second value the counter would have taken at that edge. If p >= SEC_TICKS/2, the error is SEC_TICKS - p and time_sec gets an extra increment. Otherwise the error is -p. The error appears on phase_err, and time_sub restarts at 0, so the offset to the reference stays fixed.
- R6: After acquisition, each marker adds (gain * error) >>> SHIFT to rate_word (arithmetic shift, SHIFT = 2 by default). The result is clamped to the range 1 to 2^RATE_W - 1.
- R7: A configuration write with cfg_addr 0 sets enable from cfg_wdata[0]. Address 1 sets the gain from cfg_wdata[7:0]. Address 2 sets the threshold from cfg_wdata[15:0]; values below 0x1F are stored as 0x1F.
- R8: locked rises at the LOCK_N-th consecutive post-acquisition marker (4 by default) whose error magnitude is at or below the threshold. Any marker whose error magnitude is above the threshold clears locked and the run count at once.
- R9: If no marker arrives for 1.5 × SEC_TICKS clocks, pps_timeout is set and stays set, locked is cleared, and the next marker re-acquires. Writing enable to 0 clears pps_timeout.
- R10: While disabled, rate_word is nominal, locked is 0, and markers have no effect on phase_err, rate_word or time_sub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Asynchronous once-per-second marker from the reference |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 enable, 1 gain, 2 threshold) |
| cfg_wdata | input | 16 | Configuration write data |
| time_sec | output | SEC_W | Whole-second count |
| time_sub | output | SUB_W | Sub-second tick count, below SEC_TICKS |
| rate_word | output | RATE_W | Current rate, FRAC_W fractional bits |
| phase_err | output | ERR_W | Signed error measured at the last accepted marker |
| locked | output | 1 | Lock indicator |
| pps_timeout | output | 1 | Sticky missing-marker flag |

## Verification
The checks assume that configuration writes and markers are synchronous to the block's own clock domain only after the synchronizer. They also assume that the threshold register is reached only through the write port, so its floor holds. The stimulus raises each marker at a falling edge and holds it for at least three clocks. It spaces markers between roughly 0.7 and 1.5 nominal seconds, so every gap lies below the timeout except where a timeout is the point of the test. A zero gain is used wherever exact error values must repeat from marker to marker.

// File: rtl/pps_rate_aligner.sv
module pps_rate_aligner #(
  parameter int SEC_TICKS = 2000,
  parameter int FRAC_W    = 16,
  parameter int SEC_W     = 32,
  parameter int SHIFT     = 2,
  parameter int LOCK_N    = 4,
  localparam int SUB_W    = $clog2(SEC_TICKS),
  localparam int ERR_W    = SUB_W + 1,
  localparam int RATE_W   = FRAC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pps_in,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [15:0]             cfg_wdata,
  output logic [SEC_W-1:0]        time_sec,
  output logic [SUB_W-1:0]        time_sub,
  output logic [RATE_W-1:0]       rate_word,
  output logic signed [ERR_W-1:0] phase_err,
  output logic                    locked,
  output logic                    pps_timeout
);
  localparam int TMO   = SEC_TICKS * 3 / 2;
  localparam int WD_W  = $clog2(TMO + 1);
  localparam int CNT_W = $clog2(LOCK_N + 1);
  localparam int WW    = RATE_W + ERR_W + 10;
  localparam logic [RATE_W-1:0] NOM = RATE_W'(1) << FRAC_W;
  localparam logic [15:0] THR_MIN = 16'h001F;
  localparam logic signed [WW-1:0] RMAX = WW'((64'd1 << RATE_W) - 1);
  localparam logic signed [WW-1:0] RMIN = WW'(1);

  logic              en_q, s1, s2, s3, acq_q;
  logic [7:0]        gain_q;
  logic [15:0]       thr_q;
  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  good_q;
  logic [WD_W-1:0]   wd_q;

  logic [RATE_W:0]   acc;
  logic [SUB_W:0]    nxt;
  logic [SUB_W-1:0]  nxt_w;
  logic              wrap, late, pps_evt, bad;
  logic signed [ERR_W-1:0] err_now;
  logic [ERR_W-1:0]  mag;
  logic signed [WW-1:0] gain_s, err_s, corr, rsum, rclamp;

  assign acc     = {1'b0, rate_word} + (RATE_W+1)'(frac_q);
  assign nxt     = {1'b0, time_sub} + (SUB_W+1)'(acc[RATE_W:FRAC_W]);
  assign wrap    = nxt >= (SUB_W+1)'(SEC_TICKS);
  assign nxt_w   = wrap ? SUB_W'(nxt - (SUB_W+1)'(SEC_TICKS)) : nxt[SUB_W-1:0];
  assign late    = nxt_w >= SUB_W'(SEC_TICKS / 2);
  assign err_now = late ? $signed(ERR_W'(SEC_TICKS) - {1'b0, nxt_w})
                        : -$signed({1'b0, nxt_w});
  assign mag     = err_now[ERR_W-1] ? ERR_W'(-err_now) : ERR_W'(err_now);
  assign bad     = 32'(mag) > 32'(thr_q);
  assign pps_evt = s2 & ~s3 & en_q;

  assign gain_s  = WW'(gain_q);
  assign err_s   = WW'(err_now);
  assign corr    = (gain_s * err_s) >>> SHIFT;
  assign rsum    = WW'(rate_word) + corr;
  assign rclamp  = (rsum < RMIN) ? RMIN : (rsum > RMAX) ? RMAX : rsum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      en_q        <= 1'b1;
      gain_q      <= 8'h70;
      thr_q       <= 16'h026C;
      frac_q      <= '0;
      time_sub    <= '0;
      time_sec    <= '0;
      rate_word   <= NOM;
      phase_err   <= '0;
      acq_q       <= 1'b0;
      good_q      <= '0;
      locked      <= 1'b0;
      pps_timeout <= 1'b0;
      wd_q        <= '0;
    end else begin
      s1 <= pps_in;
      s2 <= s1;
      s3 <= s2;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    en_q   <= cfg_wdata[0];
          2'd1:    gain_q <= cfg_wdata[7:0];
          2'd2:    thr_q  <= (cfg_wdata < THR_MIN) ? THR_MIN : cfg_wdata;
          default: ;
        endcase
      end
      frac_q   <= acc[FRAC_W-1:0];
      time_sub <= nxt_w;
      time_sec <= time_sec + SEC_W'(wrap);
      if (!en_q) begin
        rate_word   <= NOM;
        acq_q       <= 1'b0;
        good_q      <= '0;
        locked      <= 1'b0;
        pps_timeout <= 1'b0;
        wd_q        <= '0;
      end else if (pps_evt) begin
        frac_q    <= '0;
        time_sub  <= '0;
        time_sec  <= time_sec + SEC_W'(wrap) + SEC_W'(late);
        phase_err <= err_now;
        wd_q      <= '0;
        acq_q     <= 1'b1;
        if (acq_q) begin
          rate_word <= RATE_W'(rclamp);
          if (bad) begin
            good_q <= '0;
            locked <= 1'b0;
          end else begin
            if (good_q != CNT_W'(LOCK_N)) good_q <= good_q + 1'b1;
            if (good_q >= CNT_W'(LOCK_N - 1)) locked <= 1'b1;
          end
        end
      end else if (wd_q == WD_W'(TMO - 1)) begin
        pps_timeout <= 1'b1;
        locked      <= 1'b0;
        good_q      <= '0;
        acq_q       <= 1'b0;
        wd_q        <= '0;
      end else begin
        wd_q <= wd_q + 1'b1;
      end
    end
  end
endmodule

module pps_rate_aligner_chk #(
  parameter int SEC_TICKS = 2000,
  parameter int SUB_W     = 11,
  parameter int RATE_W    = 18,
  parameter int FRAC_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              pps_evt,
  input logic              acq_q,
  input logic [RATE_W-1:0] rate_word,
  input logic [SUB_W-1:0]  time_sub,
  input logic [15:0]       thr_q,
  input logic              locked,
  input logic              pps_timeout
);
  localparam logic [RATE_W-1:0] NOM = RATE_W'(1) << FRAC_W;

  a_r3_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(time_sub) < SEC_TICKS);
  a_r4_acquire_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_evt && !acq_q) |=> $stable(rate_word));
  a_r6_rate_moves_only_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_word) |-> ($past(pps_evt) || $past(!en_q)));
  a_r7_threshold_floor: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q >= 16'h001F);
  a_r8_lock_rises_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pps_evt));
  a_r9_timeout_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_timeout) |-> !locked);
  a_r10_disabled_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (rate_word == NOM && !locked));
endmodule

bind pps_rate_aligner pps_rate_aligner_chk #(
  .SEC_TICKS(SEC_TICKS), .SUB_W(SUB_W), .RATE_W(RATE_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pps_evt(pps_evt), .acq_q(acq_q),
  .rate_word(rate_word), .time_sub(time_sub), .thr_q(thr_q),
  .locked(locked), .pps_timeout(pps_timeout)
);

// File: tb/pps_rate_aligner_bench.sv
module pps_rate_aligner_bench;
  localparam int SEC   = 2000;
  localparam int NOM   = 65536;
  localparam int NVEC  = 6;
  // each entry: {gain (-1 keeps reset default), clocks early (negative = late)}
  localparam int VEC [NVEC][2] = '{
    '{-1, 5}, '{-1, -5}, '{255, 100}, '{1, -3}, '{0, 50}, '{128, -37}};

  logic clk = 1'b0, rst_n = 1'b0, pps_in = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] time_sec;
  logic [10:0] time_sub;
  logic [17:0] rate_word;
  logic signed [11:0] phase_err;
  logic locked, pps_timeout;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pps_rate_aligner u_pps_rate_aligner (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .time_sec(time_sec),
    .time_sub(time_sub), .rate_word(rate_word), .phase_err(phase_err),
    .locked(locked), .pps_timeout(pps_timeout));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic fire(input int w);
    pps_in = 1'b1;
    repeat (w) @(negedge clk);
    pps_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    idle(3);
    chk("R1", "time_sub", time_sub, 0);
    chk("R1", "time_sec", time_sec, 0);
    chk("R1", "rate_word", rate_word, NOM);
    chk("R1", "locked", locked, 0);
    chk("R1", "pps_timeout", pps_timeout, 0);

    // R6/R5 table: acquire, then one marker early or late
    for (int i = 0; i < NVEC; i++) begin
      int g, e, exp_rate;
      do_reset();
      g = (VEC[i][0] < 0) ? 112 : VEC[i][0];
      if (VEC[i][0] >= 0) cfg(2'd1, 16'(VEC[i][0]));
      e = VEC[i][1];
      fire(4);
      chk("R4", "rate after acquire", rate_word, NOM);
      idle(SEC - e - 4);
      fire(4);
      exp_rate = NOM + ((g * e) >>> 2);
      chk("R5", "phase_err", phase_err, e);
      chk("R6", "rate_word", rate_word, exp_rate);
      chk("R5", "time_sec", time_sec, 1);
    end

    // R6 clamp, then R10 disable
    do_reset();
    cfg(2'd1, 16'h00FF);
    fire(4);
    idle(2999 - 4);
    fire(4);
    chk("R5", "late 999 error", phase_err, -999);
    chk("R6", "rate after big step", rate_word, 1849);
    idle(SEC - 4);
    fire(4);
    chk("R3", "slow-rate error", phase_err, -56);
    chk("R6", "rate clamped", rate_word, 1);
    cfg(2'd0, 16'h0000);
    idle(2);
    chk("R10", "rate nominal when disabled", rate_word, NOM);
    fire(4);
    chk("R10", "error held while disabled", phase_err, -56);
    chk("R10", "rate held while disabled", rate_word, NOM);
    chk("R10", "locked while disabled", locked, 0);
    chk("R10", "time_sub not snapped", (time_sub == 11'd1) ? 1 : 0, 0);

    // R8/R2 default threshold 0x26C with wide markers, zero gain
    do_reset();
    cfg(2'd1, 16'h0000);
    fire(200);
    chk("R4", "time_sub after acquire", time_sub, 197);
    idle(1380 - 200);
    for (int k = 1; k <= 4; k++) begin
      fire(200);
      chk("R2", "error at threshold", phase_err, 620);
      chk("R5", "fixed offset", time_sub, 197);
      chk("R8", "lock after good run", locked, (k == 4) ? 1 : 0);
      idle(((k == 4) ? 1379 : 1380) - 200);
    end
    fire(200);
    chk("R8", "error above threshold", phase_err, 621);
    chk("R8", "lock cleared", locked, 0);
    idle(1380 - 200);
    for (int k = 1; k <= 4; k++) begin
      fire(200);
      chk("R8", "relock", locked, (k == 4) ? 1 : 0);
      idle((k == 4) ? 2700 : 1180);
    end
    // R9 timeout
    chk("R9", "no timeout before 1.5 s", pps_timeout, 0);
    chk("R9", "still locked before 1.5 s", locked, 1);
    idle(200);
    chk("R9", "timeout set", pps_timeout, 1);
    chk("R9", "lock lost", locked, 0);
    fire(4);
    chk("R9", "timeout sticky", pps_timeout, 1);
    chk("R9", "re-acquire snaps phase", time_sub, 1);
    cfg(2'd0, 16'h0000);
    idle(2);
    chk("R9", "disable clears timeout", pps_timeout, 0);

    // R7 threshold floor: write 5 behaves as 0x1F
    do_reset();
    cfg(2'd1, 16'h0000);
    cfg(2'd2, 16'h0005);
    fire(4);
    idle(1969 - 4);
    for (int k = 1; k <= 4; k++) begin
      fire(4);
      chk("R7", "lock with floor threshold", locked, (k == 4) ? 1 : 0);
      idle(((k == 4) ? 1968 : 1969) - 4);
    end
    fire(4);
    chk("R7", "error 32", phase_err, 32);
    chk("R7", "unlock above floor", locked, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule